// File: doc/BRIEF.md
# Split-Aware Priority Bus Arbiter

This block decides which of several bus masters owns a shared system bus. Each master raises a request line; the arbiter returns a one-hot grant and publishes the number of the owning master on a tag output. That tag is the master number carried by the current address phase. Grant decisions are made only on clock edges where the bus ready signal is high, so a transfer that is waiting on a slave is never handed over midway. A master that holds the bus and keeps requesting keeps the bus. When no eligible master requests, the bus parks on a default master.

The arbiter also watches the slave response lines. A SPLIT response excludes the master of the current data phase from arbitration, and that master stays excluded until the slave raises that master's release bit. A RETRY response forces the next handover to go to a master of higher priority than the retried one, if such a master is requesting. The restriction is dropped at that handover. If no higher-priority master is requesting, the normal rules apply, so the retried master can take the bus again.

Top module: `split_arbiter`

## Requirements
- R1: After reset, owner_o equals the default master (NUM_MASTERS-1), grant_o selects only that master, and no master is excluded by a split.
- R2: At an arbitration edge where the current owner is not requesting, the eligible requester with the lowest index wins. A master is eligible when it is requesting and not split-excluded; index 0 has the highest priority.
- R3: At an arbitration edge with no eligible requester, and no grant kept under R4, the bus goes to the default master.
- R4: The current owner keeps the bus while it is requesting and not split-excluded. A higher-priority request does not preempt it unless R9 applies.
- R5: An arbitration edge is a rising clock edge with ready_i high. owner_o and grant_o change only at arbitration edges.
- R6: resp_i = 2'b11 (SPLIT) sampled with ready_i low excludes the data-phase master. The data-phase master is the owner_o value held just before the most recent arbitration edge. An excluded master is not granted, except through default parking.
- R7: split_rel_i[i] high at a clock edge ends the exclusion of master i, unless a SPLIT for master i is recorded at the same edge (the SPLIT wins).
- R8: While a master is split-excluded, any other eligible master may take the bus, whatever its priority relative to the excluded one.
- R9: resp_i = 2'b10 (RETRY) sampled with ready_i low records the data-phase master as retried. At the next arbitration edge, if any eligible master with a lower index is requesting, the lowest-indexed one of them is granted, even if the retried master still requests.
- R10: The retry restriction ends at the first arbitration edge after it is recorded. At that edge, if no higher-priority eligible master requests, R2–R4 decide; after that edge they always decide.
- R11: grant_o always has exactly one bit set, at the index equal to owner_o. resp_i codes 2'b00 (OKAY) and 2'b01 (ERROR) do not affect arbitration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_MASTERS | Bus request, one bit per master |
| ready_i | input | 1 | Bus ready; high marks the end of the current transfer |
| resp_i | input | 2 | Slave response: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| split_rel_i | input | NUM_MASTERS | Slave release of a split master, one bit per master number |
| grant_o | output | NUM_MASTERS | One-hot bus grant |
| owner_o | output | TAG_W | Number of the master owning the address phase |

## Verification
The retry restriction and the rule that an owner keeps the bus both act at the same arbitration edge. This happens when the retried master is still the owner and is still requesting. The bench provokes it twice. In the first case a higher-priority master requests through the retry, and the owner must move to that master. In the second case nothing higher requests, and the retried master must keep the bus, and keep it again on the next edge once a higher master arrives. Split masking also falls in the same cycle as a handover: the second SPLIT cycle has ready high, and the grant must skip the masked master at that very edge.

// File: rtl/split_arb_pkg.sv
package split_arb_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY  = 2'b00,
    RESP_ERROR = 2'b01,
    RESP_RETRY = 2'b10,
    RESP_SPLIT = 2'b11
  } resp_e;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/split_mask.sv
module split_mask #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [N-1:0]     rel_i,
  output logic [N-1:0]     mask_o
);
  logic [N-1:0] mask_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[i] <= 1'b0;
      end else if (set_i && set_idx_i == IDX_W'(i)) begin
        mask_q[i] <= 1'b1;   // set wins over release
      end else if (rel_i[i]) begin
        mask_q[i] <= 1'b0;
      end
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/retry_guard.sv
module retry_guard #(
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] id_i,
  input  logic             clr_i,
  output logic             active_o,
  output logic [IDX_W-1:0] id_o
);
  logic             active_q;
  logic [IDX_W-1:0] id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      id_q     <= '0;
    end else if (set_i) begin
      active_q <= 1'b1;
      id_q     <= id_i;
    end else if (clr_i) begin
      active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign id_o     = id_q;
endmodule

// File: rtl/split_arbiter.sv
module split_arbiter
  import split_arb_pkg::*;
#(
  parameter int NUM_MASTERS    = 4,
  parameter int DEFAULT_MASTER = NUM_MASTERS - 1,
  parameter int TAG_W          = $clog2(NUM_MASTERS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic                   ready_i,
  input  logic [1:0]             resp_i,
  input  logic [NUM_MASTERS-1:0] split_rel_i,
  output logic [NUM_MASTERS-1:0] grant_o,
  output logic [TAG_W-1:0]       owner_o
);
  localparam logic [TAG_W-1:0] DEF_TAG = TAG_W'(DEFAULT_MASTER);

  resp_e resp;
  assign resp = resp_e'(resp_i);

  logic [TAG_W-1:0]       owner_q, data_owner_q, owner_d;
  logic [NUM_MASTERS-1:0] mask_q, eligible, higher;
  logic                   retry_q;
  logic [TAG_W-1:0]       retry_id;
  logic                   split_hit, retry_hit;
  logic                   elig_found, hi_found;
  logic [TAG_W-1:0]       elig_idx, hi_idx;

  // responses are acted on in their first (ready low) cycle
  assign split_hit = (resp == RESP_SPLIT) && !ready_i;
  assign retry_hit = (resp == RESP_RETRY) && !ready_i;

  split_mask #(.N(NUM_MASTERS), .IDX_W(TAG_W)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (split_hit),
    .set_idx_i (data_owner_q),
    .rel_i     (split_rel_i),
    .mask_o    (mask_q)
  );

  retry_guard #(.IDX_W(TAG_W)) u_retry (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (retry_hit),
    .id_i     (data_owner_q),
    .clr_i    (ready_i),
    .active_o (retry_q),
    .id_o     (retry_id)
  );

  assign eligible = req_i & ~mask_q;

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_higher
    assign higher[i] = eligible[i] && (TAG_W'(i) < retry_id);
  end

  prio_pick #(.N(NUM_MASTERS), .IDX_W(TAG_W)) u_pick_all (
    .vec_i   (eligible),
    .found_o (elig_found),
    .idx_o   (elig_idx)
  );

  prio_pick #(.N(NUM_MASTERS), .IDX_W(TAG_W)) u_pick_hi (
    .vec_i   (higher),
    .found_o (hi_found),
    .idx_o   (hi_idx)
  );

  always_comb begin
    if (retry_q && hi_found)      owner_d = hi_idx;
    else if (eligible[owner_q])   owner_d = owner_q;
    else if (elig_found)          owner_d = elig_idx;
    else                          owner_d = DEF_TAG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q      <= DEF_TAG;
      data_owner_q <= DEF_TAG;
    end else if (ready_i) begin
      owner_q      <= owner_d;
      data_owner_q <= owner_q;
    end
  end

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_grant
    assign grant_o[i] = (owner_q == TAG_W'(i));
  end

  assign owner_o = owner_q;
endmodule

// File: rtl/split_arbiter_chk.sv
module split_arbiter_chk #(
  parameter int NUM_MASTERS    = 4,
  parameter int DEFAULT_MASTER = NUM_MASTERS - 1,
  parameter int TAG_W          = $clog2(NUM_MASTERS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_MASTERS-1:0] req_i,
  input logic                   ready_i,
  input logic [1:0]             resp_i,
  input logic [NUM_MASTERS-1:0] split_rel_i,
  input logic [NUM_MASTERS-1:0] grant_o,
  input logic [TAG_W-1:0]       owner_o,
  input logic [NUM_MASTERS-1:0] mask_i,
  input logic                   retry_i
);
  assert_grant_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(grant_o) == 1) && grant_o[owner_o]);

  assert_hold_not_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(owner_o));

  assert_park_default_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && ((req_i & ~mask_i) == '0)) |=> (owner_o == TAG_W'(DEFAULT_MASTER)));

  assert_owner_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !retry_i && req_i[owner_o] && !mask_i[owner_o]) |=> $stable(owner_o));

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_m
    if (i != DEFAULT_MASTER) begin : g_nd
      assert_split_excluded_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_i && mask_i[i]) |=> (owner_o != TAG_W'(i)));
    end
    assert_release_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (split_rel_i[i] && !(resp_i == 2'b11 && !ready_i)) |=> !mask_i[i]);
  end
endmodule

bind split_arbiter split_arbiter_chk #(
  .NUM_MASTERS    (NUM_MASTERS),
  .DEFAULT_MASTER (DEFAULT_MASTER),
  .TAG_W          (TAG_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_i     (ready_i),
  .resp_i      (resp_i),
  .split_rel_i (split_rel_i),
  .grant_o     (grant_o),
  .owner_o     (owner_o),
  .mask_i      (mask_q),
  .retry_i     (retry_q)
);

// File: tb/tb_split_arbiter.sv
module tb_split_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int TW = 2;
  localparam logic [1:0] OKAY  = 2'b00;
  localparam logic [1:0] RETRY = 2'b10;
  localparam logic [1:0] SPLIT = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM-1:0] req = '0;
  logic          ready = 1'b0;
  logic [1:0]    resp = OKAY;
  logic [NM-1:0] rel = '0;
  logic [NM-1:0] grant;
  logic [TW-1:0] owner;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [TW-1:0] owner;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  split_arbiter #(.NUM_MASTERS(NM)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .ready_i     (ready),
    .resp_i      (resp),
    .split_rel_i (rel),
    .grant_o     (grant),
    .owner_o     (owner)
  );

  task automatic compare(input logic [TW-1:0] exp_owner, input string tag);
    logic [NM-1:0] exp_grant;
    exp_grant = NM'(1) << exp_owner;
    checks++;
    if (owner !== exp_owner) begin
      failures++;
      $display("FAIL %s owner actual=%0d expected=%0d", tag, owner, exp_owner);
    end
    checks++;
    if (grant !== exp_grant) begin
      failures++;
      $display("FAIL R11 (%s) grant actual=%b expected=%b", tag, grant, exp_grant);
    end
  endtask

  // driver: apply one cycle of stimulus, queue the owner expected after the edge
  task automatic drive(input logic [NM-1:0] r, input logic rdy, input logic [1:0] rs,
                       input logic [NM-1:0] rl, input logic [TW-1:0] exp_owner,
                       input string tag);
    exp_t e;
    @(negedge clk);
    req = r; ready = rdy; resp = rs; rel = rl;
    @(posedge clk);
    #1;
    e.owner = exp_owner;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      compare(e.owner, e.tag);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare(2'd3, "R1 reset parks on default");

    drive(4'b0010, 1, OKAY, 4'b0000, 2'd1, "R2 single requester");
    drive(4'b0011, 1, OKAY, 4'b0000, 2'd1, "R4 owner not preempted");
    drive(4'b0001, 0, OKAY, 4'b0000, 2'd1, "R5 no handover with ready low");
    drive(4'b0001, 1, OKAY, 4'b0000, 2'd0, "R2 handover on ready");
    drive(4'b0011, 1, OKAY, 4'b0000, 2'd0, "R4 owner 0 keeps bus");
    // split of master 0 (data phase owner 0)
    drive(4'b0011, 0, SPLIT, 4'b0000, 2'd0, "R5 split first cycle holds");
    drive(4'b0011, 1, SPLIT, 4'b0000, 2'd1, "R8 lower master granted past split");
    drive(4'b0011, 1, OKAY, 4'b0000, 2'd1, "R6 split master stays out");
    drive(4'b0001, 1, OKAY, 4'b0000, 2'd3, "R6 masked request parks default");
    drive(4'b0001, 0, OKAY, 4'b0001, 2'd3, "R5 release with ready low");
    drive(4'b0001, 1, OKAY, 4'b0000, 2'd0, "R7 released master granted");
    // retry with a higher requester
    drive(4'b0100, 1, 2'b01, 4'b0000, 2'd2, "R11 error code ignored, R2 pick");
    drive(4'b0100, 1, OKAY, 4'b0000, 2'd2, "R4 owner 2 holds");
    drive(4'b0101, 1, OKAY, 4'b0000, 2'd2, "R4 no preemption by master 0");
    drive(4'b0101, 0, RETRY, 4'b0000, 2'd2, "R5 retry first cycle holds");
    drive(4'b0101, 1, RETRY, 4'b0000, 2'd0, "R9 higher master takes bus after retry");
    // retry with no higher requester
    drive(4'b0100, 1, OKAY, 4'b0000, 2'd2, "R2 master 2 back");
    drive(4'b0100, 1, OKAY, 4'b0000, 2'd2, "R4 owner 2 holds again");
    drive(4'b0100, 0, RETRY, 4'b0000, 2'd2, "R5 retry first cycle holds");
    drive(4'b0100, 1, RETRY, 4'b0000, 2'd2, "R10 no higher request, retried keeps");
    drive(4'b0101, 1, OKAY, 4'b0000, 2'd2, "R10 restriction gone, owner holds");
    drive(4'b0000, 1, OKAY, 4'b0000, 2'd3, "R3 idle parks default");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule